// File: doc/BRIEF.md
# Dual Event Performance Counter Unit

This block gives a processor two independent hardware event counters, each 48 bits wide by default. The core drives a vector of single-cycle event strobes, one bit per event code. Each counter has its own 16-bit control register. The control register picks the event code the counter tallies, gates counting with an enable flag and a start flag, and carries a self-clearing clear flag. Software cannot load an arbitrary count. The only way to change a count is to clear it to zero. There is no overflow interrupt. At full width a counter rolls over to zero.

A count is read through two data registers. The high register returns the bits above the low-register width. The low register returns the bottom 32 bits. Reading the high register also captures the low half into a per-counter shadow. The next low read returns that shadow, so a high-then-low read pair forms one consistent snapshot. Register access uses a plain read/write strobe interface. Read data appears one cycle after the read strobe, qualified by a valid flag. No back-pressure is needed, because every register can be read or written in any cycle.

Word address map, with N counters (N = 2): counter i control at address i, counter i high at address N+2i, counter i low at address N+2i+1. Unmapped addresses read as zero, and writes to them are ignored. Writes to the count addresses are ignored.

Top module: `dual_event_pmu`

## Requirements
- R1: After reset, every control register reads 0x0000, every count reads zero and rd_valid is low.
- R2: A control register reads back with the event code in bits [5:0], the clock-select flag in bit 8, start in bit 14 and enable in bit 15. Bits 13, 12:9, 7 and 6 always read as zero.
- R3: A counter adds exactly one in each cycle where its enable (bit 15) and start (bit 14) are both set and the strobe indexed by its event code is high. With either flag clear it does not count.
- R4: Clearing the enable or start flag freezes the count at its current value.
- R5: Writing a control word with bit 13 set zeroes that counter on the write edge. The clear wins over an increment in the same cycle, and bit 13 is not stored.
- R6: Codes 0x00, 0x0C, 0x1B to 0x20, 0x26 and anything above 0x29 are unassigned and never increment the counter, whatever the strobes do.
- R7: Code 0x23 counts elapsed clocks: while enabled and started, the counter adds one every cycle regardless of the strobes.
- R8: The high register returns count bits [CNT_W-1:LO_W] right-aligned in zero. The low register returns count bits [LO_W-1:0] (by default 48 and 32). A counter at all ones wraps to zero.
- R9: A high-register read captures the low half of the same count. The next low read of that counter returns the captured value. A low read with no pending capture returns the live low half.
- R10: The two counters are configured and advance independently, and a write to one control register leaves the other counter untouched.
- R11: rd_valid is high in exactly the cycle after rd_en. The read data reflects the register state before the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_strobe | input | 64 | Event strobes, bit k is event code k |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address |
| wr_data | input | 16 | Control write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |

## Verification
The assertions assume the event strobes are meaningful only in the cycle they are high. They also assume a clear request is seen only as a control write. Neither assumption constrains the stimulus, because any strobe pattern and any write word are legal. The bench drives all inputs half a cycle before the sampling edge and holds them stable across it. It mixes directed phases with random writes, reads (including unmapped addresses) and strobe patterns. A reduced counter width lets the high half and the rollover be reached within the run.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CODE_W  = 6;
  localparam int NEV     = 1 << CODE_W;
  localparam int CTL_W   = 16;
  localparam int EN_BIT  = 15;
  localparam int ST_BIT  = 14;
  localparam int CLR_BIT = 13;
  localparam int CKS_BIT = 8;
  localparam logic [CODE_W-1:0] CODE_ELAPSED = 6'h23;
  localparam logic [CODE_W-1:0] CODE_LAST    = 6'h29;

  typedef struct packed {
    logic              enable;
    logic              start;
    logic              clk_sel;
    logic [CODE_W-1:0] code;
  } ctl_t;

  function automatic logic code_assigned(input logic [CODE_W-1:0] c);
    logic ok;
    ok = (c != '0) && (c <= CODE_LAST);
    if (c == 6'h0C || c == 6'h26) ok = 1'b0;
    if (c >= 6'h1B && c <= 6'h20) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [CTL_W-1:0] ctl_image(input ctl_t c);
    logic [CTL_W-1:0] r;
    r = '0;
    r[EN_BIT]       = c.enable;
    r[ST_BIT]       = c.start;
    r[CKS_BIT]      = c.clk_sel;
    r[CODE_W-1:0]   = c.code;
    return r;
  endfunction
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter
  import pmu_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  ctl_t             ctl_new,
  input  logic             clr_req,
  input  logic [NEV-1:0]   ev_strobe,
  output ctl_t             ctl_q,
  output logic [CNT_W-1:0] count_q
);
  logic running, hit, bump, clr;

  assign running = ctl_q.enable & ctl_q.start;
  assign hit     = (ctl_q.code == CODE_ELAPSED) |
                   (code_assigned(ctl_q.code) & ev_strobe[ctl_q.code]);
  assign bump    = running & hit;
  assign clr     = ctl_wr & clr_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      count_q <= '0;
    end else begin
      if (ctl_wr) ctl_q <= ctl_new;
      if (clr)       count_q <= '0;
      else if (bump) count_q <= count_q + 1'b1;
    end
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count_q == '0); // R5
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ctl_q.enable && ctl_q.start) && !clr) |=> $stable(count_q)); // R4
  AST_UNASSIGNED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_assigned(ctl_q.code) && ctl_q.code != CODE_ELAPSED && !clr) |=> $stable(count_q)); // R6
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count_q == $past(count_q) || count_q == CNT_W'($past(count_q) + 1'b1))); // R3
  AST_ELAPSED_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (running && ctl_q.code == CODE_ELAPSED && !clr) |=> count_q == CNT_W'($past(count_q) + 1'b1)); // R7
endmodule

// File: rtl/pmu_readport.sv
module pmu_readport
  import pmu_pkg::*;
#(
  parameter int NCNT   = 2,
  parameter int CNT_W  = 48,
  parameter int LO_W   = 32,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           rd_addr,
  input  logic [NCNT-1:0][CTL_W-1:0]  ctl_img,
  input  logic [NCNT-1:0][CNT_W-1:0]  counts,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        rd_valid
);
  localparam int HI_W = CNT_W - LO_W;

  logic [NCNT-1:0][LO_W-1:0] shadow_q;
  logic [NCNT-1:0]           armed_q;
  logic [NCNT-1:0]           hi_hit, lo_hit;
  logic [DATA_W-1:0]         rd_mux;

  always_comb begin
    rd_mux = '0;
    hi_hit = '0;
    lo_hit = '0;
    for (int i = 0; i < NCNT; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_mux = DATA_W'(ctl_img[i]);
      if (rd_addr == ADDR_W'(NCNT + 2*i)) begin
        hi_hit[i] = 1'b1;
        rd_mux    = DATA_W'(counts[i][CNT_W-1:LO_W]);
      end
      if (rd_addr == ADDR_W'(NCNT + 2*i + 1)) begin
        lo_hit[i] = 1'b1;
        rd_mux    = armed_q[i] ? DATA_W'(shadow_q[i]) : DATA_W'(counts[i][LO_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      shadow_q <= '0;
      armed_q  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
      for (int i = 0; i < NCNT; i++) begin
        if (rd_en && hi_hit[i]) begin
          shadow_q[i] <= counts[i][LO_W-1:0];
          armed_q[i]  <= 1'b1;
        end else if (rd_en && lo_hit[i]) begin
          armed_q[i]  <= 1'b0;
        end
      end
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R11
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R11

  for (genvar g = 0; g < NCNT; g++) begin : g_snap
    AST_SNAPSHOT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && hi_hit[g]) |=> shadow_q[g] == $past(counts[g][LO_W-1:0])); // R9
  end

  initial begin
    AST_SPLIT_FITS: assert (HI_W > 0 && HI_W <= DATA_W && LO_W <= DATA_W); // R8
  end
endmodule

// File: rtl/dual_event_pmu.sv
module dual_event_pmu
  import pmu_pkg::*;
#(
  parameter int NCNT   = 2,
  parameter int CNT_W  = 48,
  parameter int LO_W   = 32,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NEV-1:0]       ev_strobe,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [CTL_W-1:0]     wr_data,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_valid
);
  ctl_t                        ctl_new;
  ctl_t [NCNT-1:0]             ctl_q;
  logic [NCNT-1:0][CTL_W-1:0]  ctl_img;
  logic [NCNT-1:0][CNT_W-1:0]  counts;
  logic                        unused_wr_bits;

  assign ctl_new = '{enable:  wr_data[EN_BIT],
                     start:   wr_data[ST_BIT],
                     clk_sel: wr_data[CKS_BIT],
                     code:    wr_data[CODE_W-1:0]};
  assign unused_wr_bits = ^{wr_data[12:9], wr_data[7:6]};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    pmu_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (wr_en && addr == ADDR_W'(g)),
      .ctl_new   (ctl_new),
      .clr_req   (wr_data[CLR_BIT]),
      .ev_strobe (ev_strobe),
      .ctl_q     (ctl_q[g]),
      .count_q   (counts[g])
    );
    assign ctl_img[g] = ctl_image(ctl_q[g]);

    AST_OTHER_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr != ADDR_W'(g)) |=> $stable(ctl_q[g])); // R10
  end

  pmu_readport #(
    .NCNT(NCNT), .CNT_W(CNT_W), .LO_W(LO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (addr),
    .ctl_img  (ctl_img),
    .counts   (counts),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );
endmodule

// File: tb/dual_event_pmu_tb.sv
`timescale 1ns/1ps
module dual_event_pmu_tb;
  localparam int CNT_W = 14;
  localparam int LO_W  = 8;
  localparam longint CMASK = (64'd1 << CNT_W) - 1;
  localparam longint LMASK = (64'd1 << LO_W) - 1;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] ev_strobe = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [2:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int checks = 0, failures = 0;
  string cur_req = "R1";

  longint     mcnt[2];
  logic [15:0] mctl[2];
  longint     msh[2];
  bit         marm[2];
  bit         exp_valid;
  longint     exp_data;
  logic [63:0] ev_bg = '0;

  always #2.5 clk = ~clk;

  dual_event_pmu #(.CNT_W(CNT_W), .LO_W(LO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid));

  function automatic bit is_legal(int c);
    if (c < 1 || c > 41) return 0;
    if (c == 12 || c == 38) return 0;
    if (c >= 27 && c <= 32) return 0;
    return 1;
  endfunction

  task automatic model_step(bit w, bit r, int a, logic [15:0] wd, logic [63:0] ev);
    exp_valid = r;
    exp_data  = 0;
    if (r) begin
      if (a < 2) exp_data = mctl[a];
      else if (a < 6) begin
        int k = (a - 2) / 2;
        if (a % 2 == 0) begin
          exp_data = mcnt[k] >> LO_W;
          msh[k] = mcnt[k] & LMASK;
          marm[k] = 1;
        end else begin
          exp_data = marm[k] ? msh[k] : (mcnt[k] & LMASK);
          marm[k] = 0;
        end
      end
    end
    for (int i = 0; i < 2; i++) begin
      int code = mctl[i][5:0];
      bit go = mctl[i][15] && mctl[i][14] && (code == 35 || (is_legal(code) && ev[code]));
      if (w && a == i && wd[13]) mcnt[i] = 0;
      else if (go) mcnt[i] = (mcnt[i] + 1) & CMASK;
      if (w && a == i) mctl[i] = wd & 16'hC13F;
    end
  endtask

  task automatic cyc(bit w, bit r, int a, logic [15:0] wd, logic [63:0] ev);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a[2:0]; wr_data = wd; ev_strobe = ev;
    model_step(w, r, a, wd, ev);
    @(posedge clk); #1;
    checks++;
    if (rd_valid !== exp_valid) begin
      failures++;
      $display("FAIL R11 rd_valid actual=%0b expected=%0b", rd_valid, exp_valid);
    end
    if (exp_valid) begin
      checks++;
      if (rd_data !== 32'(exp_data)) begin
        failures++;
        $display("FAIL %s addr=%0d actual=%0h expected=%0h", cur_req, a, rd_data, exp_data);
      end
    end
  endtask

  task automatic wr(int a, logic [15:0] d); cyc(1, 0, a, d, ev_bg); endtask
  task automatic rd(int a);                 cyc(0, 1, a, 16'h0, ev_bg); endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 16'h0, ev_bg);
  endtask
  task automatic rd_all();
    for (int a = 0; a < 6; a++) rd(a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin mcnt[i] = 0; mctl[i] = 0; msh[i] = 0; marm[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state
    cur_req = "R1";
    checks++;
    if (rd_valid !== 1'b0) begin failures++; $display("FAIL R1 rd_valid actual=%0b expected=0", rd_valid); end
    rd_all(); rd(6); rd(7);
    // R2: control readback, reserved bits zero
    cur_req = "R2";
    wr(0, 16'hDFFF); rd(0);
    wr(1, 16'h2140); rd(1);
    wr(0, 16'h0000); wr(1, 16'h0000); rd(0); rd(1);
    // R3: both flags needed
    cur_req = "R3";
    ev_bg = 64'h2;
    wr(0, 16'h8001); idle(5); rd(3);
    wr(0, 16'h4001); idle(5); rd(3);
    wr(0, 16'hC001);
    for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, (i % 3 == 0) ? 64'h2 : 64'h4);
    rd(2); rd(3);
    // R10: both counters together on different events
    cur_req = "R10";
    wr(1, 16'hC010);
    for (int i = 0; i < 60; i++) cyc(0, 0, 0, 0, {$urandom, $urandom});
    rd_all();
    wr(1, 16'hC011); rd(3); rd(5);
    // R4: freeze by clearing enable / start
    cur_req = "R4";
    ev_bg = '1;
    wr(0, 16'h4001); idle(10); rd(3);
    wr(1, 16'h8011); idle(10); rd(5);
    // R5: clear wins over increment, bit 13 not stored
    cur_req = "R5";
    wr(0, 16'hC001); idle(3);
    wr(0, 16'hE001); rd(3); rd(0); idle(4); rd(3);
    wr(1, 16'hA011); rd(5); rd(1);
    // R6: unassigned codes never count
    cur_req = "R6";
    wr(0, 16'h2000);
    begin
      int bad[10] = '{0, 12, 27, 29, 32, 38, 42, 50, 62, 63};
      foreach (bad[j]) begin
        wr(0, 16'hC000 | 16'(bad[j])); idle(6); rd(2); rd(3);
      end
    end
    // R7: elapsed time ignores strobes
    cur_req = "R7";
    ev_bg = '0;
    wr(0, 16'hE023); idle(25); rd(3);
    // R8: carry into high half and rollover at full width
    cur_req = "R8";
    for (int b = 0; b < 17; b++) begin idle(997); rd(2); rd(3); end
    // R9: snapshot consistency
    cur_req = "R9";
    rd(2); idle(7); rd(3); rd(3);
    rd(4); wr(1, 16'hC023); idle(5); rd(5);
    // random mix
    cur_req = "R10";
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 9);
      logic [15:0] d = 16'($urandom);
      if (k == 0) cyc(1, 0, $urandom_range(0, 7), d & 16'hDFFF, {$urandom, $urandom});
      else if (k == 1) cyc(1, 1, $urandom_range(0, 7), d, {$urandom, $urandom});
      else if (k < 5) cyc(0, 1, $urandom_range(0, 7), 0, {$urandom, $urandom});
      else cyc(0, 0, 0, 0, {$urandom, $urandom});
    end
    rd_all();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule